// File: doc/BRIEF.md
# Standby and Active Mode Sequencer

This block decides whether the device is asleep or working. In standby every output stage is held in high impedance, the analog section is off and the serial port is not ready. A falling edge on the active-low serial chip-select line is the wake-up signal. The sequencer then switches on the analog section and runs a fixed wake-up delay. Serial traffic is treated as valid only after that delay ends.

Once the delay ends, the outputs are released and the sequencer waits for the decoded mode bit of the control register. While the bit is 1 the device stays active. While the bit is 0 and chip select is idle high, a standby-return timer runs. Any chip-select low during that timer restarts it. When the timer ends, the sequencer goes back to standby and emits a one-cycle register-clear pulse. Both delays are counted in clock cycles and set by parameters, so a testbench can use short values.

The chip-select input is asynchronous and passes through a synchronizer. The mode bit comes from the same clock domain. All outputs are registered.

Top module: `mode_ctl`

## Requirements
- R1: After reset the block is in standby: `out_hiz`=1, `analog_en`=0, `spi_ready`=0, `reg_clear`=0.
- R2: In standby, `cs_n` held low wakes the block. The outputs change on the (SYNC_STAGES+1)-th rising edge after `cs_n` is first sampled low: `analog_en`=1, `out_hiz` stays 1, `spi_ready`=0. `mode_bit` alone does not wake the block.
- R3: The wake-up phase lasts exactly WAKE_CYC cycles. After it, `spi_ready`=1 and `out_hiz`=0. Chip-select activity during the wake-up phase does not change this length.
- R4: After wake-up, with `mode_bit`=0 and `cs_n` high, the block returns to standby exactly SBY_CYC cycles after `spi_ready` rose.
- R5: With `mode_bit`=1 after wake-up, the block stays ready with outputs released for as long as the bit stays 1, whatever `cs_n` does.
- R6: During the standby-return delay, a low level on `cs_n` restarts the delay. The return then happens SBY_CYC cycles after the last cycle in which the synchronized chip select was low, which is SYNC_STAGES+SBY_CYC cycles after `cs_n` rises.
- R7: When the block is active, the return delay starts only while `mode_bit`=0 and the synchronized chip select is high. Standby follows SBY_CYC+1 cycles after the later of those two conditions is seen.
- R8: On every entry into standby, `reg_clear` is 1 for exactly one cycle. In that cycle `out_hiz`=1 and `analog_en`=0, and `spi_ready` is 0 in that cycle (it was 1 in the cycle before).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous; also the wake-up request |
| mode_bit | input | 1 | Decoded mode bit of the control register (1 = stay active) |
| reg_clear | output | 1 | One-cycle pulse that clears the register file on entry to standby |
| out_hiz | output | 1 | 1 = all output stages forced to high impedance |
| analog_en | output | 1 | Enables the analog section |
| spi_ready | output | 1 | Serial accesses are valid |

## Verification
The checker watches every cycle for these rules:
- the clear pulse is a single cycle, lands on the standby output pattern, and is preceded by a ready cycle;
- outputs are never released while the analog section is off;
- `spi_ready` rises only after exactly WAKE_CYC cycles of wake-up;
- a held mode bit keeps the block ready.

Exact latencies need planned stimulus, so only the bench scenarios can show them. These cover the wake latency through the synchronizer, the length of the return delay, its restart by a chip-select pulse, and the effect of a chip select held low while the mode bit drops.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_WAKE    = 2'd1,
    ST_GRACE   = 2'd2,
    ST_ACTIVE  = 2'd3
  } mc_state_t;
endpackage

// File: rtl/mode_sync.sv
// Multi-flop synchronizer for an active-low level; idles high in reset.
module mode_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mode_timer.sv
// Saturating up-counter; done while the count equals the last value.
module mode_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] last,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)    cnt_q <= '0;
    else if (cnt_q != last) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == last);
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
  import mode_ctl_pkg::*;
#(
  parameter int unsigned WAKE_CYC    = 2000000,
  parameter int unsigned SBY_CYC     = 1600000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic mode_bit,
  output logic reg_clear,
  output logic out_hiz,
  output logic analog_en,
  output logic spi_ready
);
  localparam int unsigned MAX_CYC = (WAKE_CYC > SBY_CYC) ? WAKE_CYC : SBY_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] SBY_LAST  = CW'(SBY_CYC - 1);

  logic          cs_s;
  mc_state_t     st_q, st_d;
  logic          restart;
  logic          done;
  logic [CW-1:0] last;

  mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cs_n),
    .dout (cs_s)
  );

  assign last = (st_q == ST_WAKE) ? WAKE_LAST : SBY_LAST;

  mode_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .last    (last),
    .done    (done)
  );

  always_comb begin
    st_d    = st_q;
    restart = 1'b0;
    unique case (st_q)
      ST_STANDBY: if (!cs_s) st_d = ST_WAKE;
      ST_WAKE:    if (done)  st_d = ST_GRACE;
      ST_GRACE: begin
        if (mode_bit)   st_d    = ST_ACTIVE;
        else if (!cs_s) restart = 1'b1;
        else if (done)  st_d    = ST_STANDBY;
      end
      ST_ACTIVE:  if (!mode_bit && cs_s) st_d = ST_GRACE;
      default:    st_d = ST_STANDBY;
    endcase
    if (st_d != st_q) restart = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_STANDBY;
      reg_clear <= 1'b0;
      out_hiz   <= 1'b1;
      analog_en <= 1'b0;
      spi_ready <= 1'b0;
    end else begin
      st_q      <= st_d;
      reg_clear <= (st_q == ST_GRACE) && (st_d == ST_STANDBY);
      out_hiz   <= (st_d == ST_STANDBY) || (st_d == ST_WAKE);
      analog_en <= (st_d != ST_STANDBY);
      spi_ready <= (st_d == ST_GRACE) || (st_d == ST_ACTIVE);
    end
  end
endmodule

// File: rtl/mode_ctl_chk.sv
module mode_ctl_chk #(
  parameter int unsigned WAKE_CYC = 2000000
) (
  input logic clk,
  input logic rst,
  input logic mode_bit,
  input logic reg_clear,
  input logic out_hiz,
  input logic analog_en,
  input logic spi_ready
);
  int unsigned wake_cnt;

  always_ff @(posedge clk) begin
    if (rst)                         wake_cnt <= 0;
    else if (analog_en && !spi_ready) wake_cnt <= wake_cnt + 1;
    else                             wake_cnt <= 0;
  end

  // R8
  p_clr_single_r8: assert property (@(posedge clk) disable iff (rst)
    reg_clear |=> !reg_clear);
  p_clr_standby_r8: assert property (@(posedge clk) disable iff (rst)
    reg_clear |-> (out_hiz && !analog_en && !spi_ready && $past(spi_ready)));
  // R1
  p_hiz_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !analog_en |-> out_hiz);
  // R2
  p_wake_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(analog_en) |-> (out_hiz && !spi_ready));
  // R3
  p_wake_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_ready) |-> (wake_cnt == WAKE_CYC && !out_hiz));
  // R5
  p_hold_active_r5: assert property (@(posedge clk) disable iff (rst)
    (spi_ready && mode_bit) |=> spi_ready);
endmodule

bind mode_ctl mode_ctl_chk #(.WAKE_CYC(WAKE_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode_bit  (mode_bit),
  .reg_clear (reg_clear),
  .out_hiz   (out_hiz),
  .analog_en (analog_en),
  .spi_ready (spi_ready)
);

// File: tb/mode_ctl_tb_top.sv
`timescale 1ns/1ps
module mode_ctl_tb_top;
  localparam int W = 20;
  localparam int S = 30;
  localparam int SY = 2;
  // vector = {reg_clear, spi_ready, analog_en, out_hiz}
  localparam logic [3:0] V_SB  = 4'b0001;
  localparam logic [3:0] V_WK  = 4'b0011;
  localparam logic [3:0] V_RD  = 4'b0110;
  localparam logic [3:0] V_SBC = 4'b1001;

  typedef struct {
    int         cyc;
    logic [3:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic mode_bit = 1'b0;
  logic reg_clear, out_hiz, analog_en, spi_ready;

  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;
  logic [3:0] prev_v;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mode_ctl #(.WAKE_CYC(W), .SBY_CYC(S), .SYNC_STAGES(SY)) dut_i (
    .clk (clk), .rst (rst), .cs_n (cs_n), .mode_bit (mode_bit),
    .reg_clear (reg_clear), .out_hiz (out_hiz),
    .analog_en (analog_en), .spi_ready (spi_ready)
  );

  function automatic logic [3:0] cur_v();
    return {reg_clear, spi_ready, analog_en, out_hiz};
  endfunction

  task automatic expect_ev(input int c, input logic [3:0] v, input string tag);
    exp_t e;
    e.cyc = c; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_now(input logic [3:0] v, input string tag);
    n_run++;
    if (cur_v() !== v) begin
      n_fail++;
      $display("FAIL %s cyc %0d: got %b expected %b", tag, cyc, cur_v(), v);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wake(output int g);
    int d;
    d = cyc;
    cs_n = 1'b0;
    expect_ev(d + SY + 1, V_WK, "R2");
    g = d + SY + 1 + W;
    expect_ev(g, V_RD, "R3");
  endtask

  // monitor: compare each output change against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (cur_v() !== prev_v) begin
        n_run++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected change cyc %0d: got %b expected %b", cyc, cur_v(), prev_v);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.cyc != cyc || e.v !== cur_v()) begin
            n_fail++;
            $display("FAIL %s: got %b at cyc %0d expected %b at cyc %0d",
                     e.tag, cur_v(), cyc, e.v, e.cyc);
          end
        end
      end
      prev_v = cur_v();
    end
  end

  initial begin
    int g, h, a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now(V_SB, "R1");
    prev_v = cur_v();
    mon_on = 1'b1;

    // R2: mode bit alone does not wake
    mode_bit = 1'b1;
    repeat (15) @(negedge clk);
    check_now(V_SB, "R2");
    mode_bit = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R8: wake with short pulse, timeout back to standby
    wake(g);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    expect_ev(g + S, V_SBC, "R4");
    expect_ev(g + S + 1, V_SB, "R8");
    wait_until(g + S + 10);

    // R6: chip-select pulse during return delay restarts it
    wake(g);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    wait_until(g + 5);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    h = cyc;
    expect_ev(h + SY + S, V_SBC, "R6");
    expect_ev(h + SY + S + 1, V_SB, "R8");
    wait_until(h + S + 10);

    // R3 R5 R7: cs held low through wake, then mode=1 keeps active
    wake(g);
    wait_until(g - 5);
    cs_n = 1'b1;
    wait_until(g + 3);
    mode_bit = 1'b1;
    wait_until(g + 3 + 2 * S);
    check_now(V_RD, "R5");
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * S) @(negedge clk);
    check_now(V_RD, "R5");
    // R7: mode drops while cs low: stays active until cs rises
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    mode_bit = 1'b0;
    repeat (S + 10) @(negedge clk);
    check_now(V_RD, "R7");
    cs_n = 1'b1;
    h = cyc;
    expect_ev(h + SY + 1 + S, V_SBC, "R7");
    expect_ev(h + SY + 2 + S, V_SB, "R8");
    wait_until(h + 2);
    check_now(V_RD, "R7");
    wait_until(h + S + 10);

    // R7: plain mode drop with cs idle
    wake(g);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    wait_until(g + 2);
    mode_bit = 1'b1;
    repeat (10) @(negedge clk);
    mode_bit = 1'b0;
    a = cyc;
    expect_ev(a + 1 + S, V_SBC, "R7");
    expect_ev(a + 2 + S, V_SB, "R8");
    wait_until(a + S + 10);
    check_now(V_SB, "R8");

    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R4 pending events: got %0d expected 0", q.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule